// File: doc/BRIEF.md
# Single-Cell Charge Cycle Sequencer

This block is the digital controller of a linear single-cell lithium charger. It reads clean comparator flags from the analog front end and walks the battery through a charge cycle. Deeply discharged cells get a reduced conditioning current. Cells above the low-voltage threshold get full current until the regulation voltage is reached, and charging then ends on a taper or termination current condition. The block drives the current-path controls, a power-good indication and two active-high "pull-down on" status bits for open-drain status pins.

Three safety timers advance only on a one-second tick: conditioning, full-charge and taper. Their limits are parameters, so a bench can use short counts. A thermal or battery-temperature problem suspends charging without losing the timer contents. Once charging has ended, or a timer has faulted, a drop below the recharge threshold hands control to a separate battery-absent detector over a request/done/result handshake. An active-low enable controls charging as a whole. A second active-low enable controls the full-charge timer and termination.

Top module: `cellchg_seq`

## Requirements
- R1: While reset is applied or `supply_ok` is low, `pgood_on`, `stat1_on`, `stat2_on`, `sel_precharge`, `fast_en` and `absent_req` are 0 and `charger_off` is 1. A low `supply_ok` reaches the outputs one clock later.
- R2: When a cycle starts with `bat_below_low` high, `sel_precharge` and `stat1_on` are 1 and `fast_en` is 0.
- R3: If the conditioning timer counts PRE_LIMIT ticks while conditioning, the next clock turns the current path off and clears both status bits. `pgood_on` stays 1. One tick fewer leaves the block conditioning.
- R4: When `bat_below_low` falls, the block switches to full charge (`fast_en`=1, `stat1_on`=1) and clears all timers. If the full-charge timer then reaches FAST_LIMIT ticks, the block enters a timer fault.
- R5: During full charge with `bat_at_reg` and `cur_below_taper` both high, the taper timer counts ticks. Charge ends exactly when the count reaches TAPER_LIMIT, which gives `stat2_on`=1, `stat1_on`=0 and `charger_off`=1. A cycle with `cur_below_taper` low clears the count.
- R6: During full charge, `bat_at_reg` and `cur_below_term` both high end the charge on the next clock, with no taper ticks needed.
- R7: `temp_ok` low or `die_hot` high turns the current path off and both status bits off, in the same cycle. Timers hold their counts during the suspend, and charging resumes in the same phase when the condition clears.
- R8: `chg_en_n` high turns charging off (`charger_off`=1, both status bits 0). When it goes low again, a new cycle starts with all timers and faults cleared.
- R9: While `tte_n` is high, the full-charge timer does not count and no termination takes place. A falling edge of `tte_n` clears all timers.
- R10: `stat1_on`/`stat2_on` are 1/0 while charging, 0/1 when charging has ended, and 0/0 in suspend, fault, battery-absent, disabled and sleep.
- R11: After charge end, `bat_below_rch` high raises `absent_req`. When `absent_done` arrives, `absent_found`=1 gives the absent state, with status 0/0. `absent_found`=0 starts a new charge cycle. From the absent state, `bat_below_rch` low starts a new cycle.
- R12: A timer fault entered with `bat_below_rch` high waits for `bat_below_rch` to go low and then high again before it raises `absent_req`.
- R13: During full charge, `bat_below_low` high returns the block to conditioning with the conditioning timer cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Input supply valid above battery |
| bat_below_low | input | 1 | Battery below the conditioning threshold |
| bat_below_rch | input | 1 | Battery below the recharge threshold |
| bat_at_reg | input | 1 | Battery at regulation voltage |
| cur_below_taper | input | 1 | Charge current below taper level |
| cur_below_term | input | 1 | Charge current below termination level |
| temp_ok | input | 1 | Battery temperature in range |
| die_hot | input | 1 | Die over temperature |
| chg_en_n | input | 1 | Active-low charge enable |
| tte_n | input | 1 | Active-low full-charge timer and termination enable |
| tick_1s | input | 1 | One-cycle pulse per second |
| absent_done | input | 1 | Absent detector finished |
| absent_found | input | 1 | Absent detector result, 1 = no battery |
| sel_precharge | output | 1 | Select conditioning current |
| fast_en | output | 1 | Enable full charge current / voltage loop |
| charger_off | output | 1 | Pass device off |
| stat1_on | output | 1 | Status pin 1 pull-down on |
| stat2_on | output | 1 | Status pin 2 pull-down on |
| pgood_on | output | 1 | Power-good pull-down on |
| absent_req | output | 1 | Request battery-absent test |

## Verification
The properties assume that every input flag is already synchronous to `clk`. They also assume that `absent_done` comes only while `absent_req` is high, and that `tick_1s` is a single-cycle pulse. The stimulus changes inputs only on the falling clock edge. It pulses the tick for exactly one cycle with idle cycles in between, and it pulses `absent_done` only after `absent_req` has been observed. Timer limits are cut to a few ticks so that every expiry boundary can be reached in both directions: one tick short of the limit and exactly at it.

// File: rtl/cellchg_pkg.sv
// Shared types for the charge cycle sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cellchg_pkg;

    // Sequencer states. Charging phases are PRE and FAST; suspend is a
    // qualifier applied on top of them, not a state.
    typedef enum logic [3:0] {
        ST_SLEEP  = 4'd0,
        ST_OFF    = 4'd1,
        ST_PRE    = 4'd2,
        ST_FAST   = 4'd3,
        ST_DONE   = 4'd4,
        ST_FLT_LO = 4'd5,
        ST_FLT_HI = 4'd6,
        ST_CHECK  = 4'd7,
        ST_ABSENT = 4'd8
    } seq_state_t;

    // Timer slots, used as indices into the timer control vectors.
    localparam int TMR_PRE   = 0;
    localparam int TMR_FAST  = 1;
    localparam int TMR_TAPER = 2;
    localparam int TMR_COUNT = 3;

endpackage

// File: rtl/cellchg_edge_det.sv
// Falling-edge detector for a group of level inputs.
// Assumes: inputs are synchronous to clk. The history resets to 0, so a
// level that is low at reset never produces an edge.
module cellchg_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] fell
);
    logic [N-1:0] prev_q;

    // Keep each input's previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl;
    end

    // One-cycle pulse per bit when it goes from high to low.
    for (genvar i = 0; i < N; i++) begin : g_fall
        assign fell[i] = prev_q[i] & ~lvl[i];
    end
endmodule

// File: rtl/cellchg_tick_timer.sv
// Saturating safety timer that advances on a tick pulse.
// Assumes: tick is one clock wide. clr has priority over run. expired is
// high once the count is at or above LIMIT, and the count then stops.
module cellchg_tick_timer #(
    parameter int LIMIT = 2065
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Expiry is a greater-or-equal compare against the limit.
    assign expired = (cnt_q >= LIM);

    // Clear, hold or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr)                      cnt_q <= '0;
        else if (run && tick && !expired)  cnt_q <= cnt_q + CW'(1);
    end
endmodule

// File: rtl/cellchg_fsm.sv
// Charge cycle state machine with output decode and timer control.
// Assumes: all flags are synchronous. tmr_exp comes from timers driven by
// tmr_clr/tmr_run. en_fell and tte_fell are one-cycle edge pulses.
module cellchg_fsm
    import cellchg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_ok,
    input  logic                 bat_below_low,
    input  logic                 bat_below_rch,
    input  logic                 bat_at_reg,
    input  logic                 cur_below_taper,
    input  logic                 cur_below_term,
    input  logic                 temp_ok,
    input  logic                 die_hot,
    input  logic                 chg_en_n,
    input  logic                 tte_n,
    input  logic                 en_fell,
    input  logic                 tte_fell,
    input  logic                 absent_done,
    input  logic                 absent_found,
    input  logic [TMR_COUNT-1:0] tmr_exp,
    output logic [TMR_COUNT-1:0] tmr_clr,
    output logic [TMR_COUNT-1:0] tmr_run,
    output logic                 sel_precharge,
    output logic                 fast_en,
    output logic                 charger_off,
    output logic                 stat1_on,
    output logic                 stat2_on,
    output logic                 pgood_on,
    output logic                 absent_req
);
    seq_state_t st_q, st_d;
    logic       clr_all;
    logic       charging;
    logic       susp;
    logic       tte_en;
    logic       taper_cond;
    seq_state_t start_st;
    seq_state_t fault_st;

    assign charging   = (st_q == ST_PRE) || (st_q == ST_FAST);
    assign susp       = charging && (!temp_ok || die_hot);
    assign tte_en     = !tte_n;
    assign taper_cond = bat_at_reg && cur_below_taper;
    assign start_st   = bat_below_low ? ST_PRE : ST_FAST;
    assign fault_st   = bat_below_rch ? ST_FLT_LO : ST_FLT_HI;

    // Next-state selection: supply, enable and edge events first, then phase.
    always_comb begin
        st_d    = st_q;
        clr_all = 1'b0;
        if (!supply_ok) begin
            st_d    = ST_SLEEP;
            clr_all = 1'b1;
        end else if (chg_en_n) begin
            st_d    = ST_OFF;
            clr_all = 1'b1;
        end else if (en_fell || st_q == ST_SLEEP || st_q == ST_OFF) begin
            st_d    = start_st;
            clr_all = 1'b1;
        end else if (tte_fell) begin
            clr_all = 1'b1;
        end else begin
            case (st_q)
                ST_PRE: begin
                    if (!susp) begin
                        if (tmr_exp[TMR_PRE]) begin
                            st_d = fault_st;
                        end else if (!bat_below_low) begin
                            st_d    = ST_FAST;
                            clr_all = 1'b1;
                        end
                    end
                end
                ST_FAST: begin
                    if (!susp) begin
                        if (bat_below_low) begin
                            st_d    = ST_PRE;
                            clr_all = 1'b1;
                        end else if (tte_en && tmr_exp[TMR_FAST]) begin
                            st_d = fault_st;
                        end else if (tte_en && bat_at_reg && cur_below_term) begin
                            st_d = ST_DONE;
                        end else if (tte_en && tmr_exp[TMR_TAPER]) begin
                            st_d = ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    if (bat_below_rch) st_d = ST_CHECK;
                end
                ST_FLT_LO: begin
                    if (!bat_below_rch) st_d = ST_FLT_HI;
                end
                ST_FLT_HI: begin
                    if (bat_below_rch) st_d = ST_CHECK;
                end
                ST_CHECK: begin
                    if (absent_done) begin
                        if (absent_found) begin
                            st_d = ST_ABSENT;
                        end else begin
                            st_d    = start_st;
                            clr_all = 1'b1;
                        end
                    end
                end
                ST_ABSENT: begin
                    if (!bat_below_rch) begin
                        st_d    = start_st;
                        clr_all = 1'b1;
                    end
                end
                default: st_d = ST_SLEEP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_SLEEP;
        else        st_q <= st_d;
    end

    // Timer controls: run only in the owning phase and never while suspended.
    always_comb begin
        tmr_run[TMR_PRE]   = (st_q == ST_PRE) && !susp;
        tmr_run[TMR_FAST]  = (st_q == ST_FAST) && !susp && tte_en;
        tmr_run[TMR_TAPER] = (st_q == ST_FAST) && !susp && tte_en && taper_cond;
        tmr_clr[TMR_PRE]   = clr_all;
        tmr_clr[TMR_FAST]  = clr_all;
        tmr_clr[TMR_TAPER] = clr_all ||
                             ((st_q == ST_FAST) && !susp && !(tte_en && taper_cond));
    end

    // Output decode from the state and the suspend qualifier.
    always_comb begin
        sel_precharge = (st_q == ST_PRE) && !susp;
        fast_en       = (st_q == ST_FAST) && !susp;
        charger_off   = !(sel_precharge || fast_en);
        stat1_on      = charging && !susp;
        stat2_on      = (st_q == ST_DONE);
        pgood_on      = (st_q != ST_SLEEP);
        absent_req    = (st_q == ST_CHECK);
    end
endmodule

// File: rtl/cellchg_seq.sv
// Top level of the charge cycle sequencer: edge detection, three safety
// timers and the state machine.
// Assumes: all inputs synchronous to clk; tick_1s is a one-cycle pulse.
module cellchg_seq
    import cellchg_pkg::*;
#(
    parameter int PRE_LIMIT   = 2065,
    parameter int FAST_LIMIT  = 20650,
    parameter int TAPER_LIMIT = 2065
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic bat_below_low,
    input  logic bat_below_rch,
    input  logic bat_at_reg,
    input  logic cur_below_taper,
    input  logic cur_below_term,
    input  logic temp_ok,
    input  logic die_hot,
    input  logic chg_en_n,
    input  logic tte_n,
    input  logic tick_1s,
    input  logic absent_done,
    input  logic absent_found,
    output logic sel_precharge,
    output logic fast_en,
    output logic charger_off,
    output logic stat1_on,
    output logic stat2_on,
    output logic pgood_on,
    output logic absent_req
);
    logic [1:0]           fell;
    logic [TMR_COUNT-1:0] tmr_clr;
    logic [TMR_COUNT-1:0] tmr_run;
    logic [TMR_COUNT-1:0] tmr_exp;

    // Edge detection on the two enables: bit 0 charge, bit 1 timer/term.
    cellchg_edge_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({tte_n, chg_en_n}),
        .fell (fell)
    );

    // One timer per slot, limit chosen by slot index.
    for (genvar t = 0; t < TMR_COUNT; t++) begin : g_tmr
        localparam int LIM = (t == TMR_PRE)  ? PRE_LIMIT :
                             (t == TMR_FAST) ? FAST_LIMIT : TAPER_LIMIT;
        cellchg_tick_timer #(.LIMIT(LIM)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (tmr_clr[t]),
            .run    (tmr_run[t]),
            .tick   (tick_1s),
            .expired(tmr_exp[t])
        );
    end

    cellchg_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .supply_ok      (supply_ok),
        .bat_below_low  (bat_below_low),
        .bat_below_rch  (bat_below_rch),
        .bat_at_reg     (bat_at_reg),
        .cur_below_taper(cur_below_taper),
        .cur_below_term (cur_below_term),
        .temp_ok        (temp_ok),
        .die_hot        (die_hot),
        .chg_en_n       (chg_en_n),
        .tte_n          (tte_n),
        .en_fell        (fell[0]),
        .tte_fell       (fell[1]),
        .absent_done    (absent_done),
        .absent_found   (absent_found),
        .tmr_exp        (tmr_exp),
        .tmr_clr        (tmr_clr),
        .tmr_run        (tmr_run),
        .sel_precharge  (sel_precharge),
        .fast_en        (fast_en),
        .charger_off    (charger_off),
        .stat1_on       (stat1_on),
        .stat2_on       (stat2_on),
        .pgood_on       (pgood_on),
        .absent_req     (absent_req)
    );
endmodule

// File: rtl/cellchg_seq_checker.sv
// Port-level properties of the charge cycle sequencer, bound to the top.
// Assumes: inputs change away from the rising clock edge.
module cellchg_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic supply_ok,
    input logic temp_ok,
    input logic die_hot,
    input logic chg_en_n,
    input logic sel_precharge,
    input logic fast_en,
    input logic charger_off,
    input logic stat1_on,
    input logic stat2_on,
    input logic pgood_on,
    input logic absent_req
);
    assert_supply_loss_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!pgood_on && !stat1_on && !stat2_on && charger_off));

    assert_one_current_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_precharge && fast_en));

    assert_suspend_no_current_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!temp_ok || die_hot) |-> (!sel_precharge && !fast_en && !stat1_on));

    assert_disabled_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en_n |=> (charger_off && !stat1_on && !stat2_on));

    assert_status_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(stat1_on && stat2_on));

    assert_stat1_means_current_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stat1_on |-> !charger_off);

    assert_check_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        absent_req |-> (charger_off && !stat1_on && !stat2_on));
endmodule

bind cellchg_seq cellchg_seq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .supply_ok    (supply_ok),
    .temp_ok      (temp_ok),
    .die_hot      (die_hot),
    .chg_en_n     (chg_en_n),
    .sel_precharge(sel_precharge),
    .fast_en      (fast_en),
    .charger_off  (charger_off),
    .stat1_on     (stat1_on),
    .stat2_on     (stat2_on),
    .pgood_on     (pgood_on),
    .absent_req   (absent_req)
);

// File: tb/cellchg_seq_bench.sv
module cellchg_seq_bench;
    localparam int PRE_L   = 8;
    localparam int FAST_L  = 20;
    localparam int TAPER_L = 5;

    // Output vector: pgood, stat1, stat2, charger_off, sel_pre, fast_en, absent_req
    localparam logic [6:0] O_SLEEP = 7'b0_00_1_00_0;
    localparam logic [6:0] O_PRE   = 7'b1_10_0_10_0;
    localparam logic [6:0] O_FAST  = 7'b1_10_0_01_0;
    localparam logic [6:0] O_IDLE  = 7'b1_00_1_00_0;
    localparam logic [6:0] O_DONE  = 7'b1_01_1_00_0;
    localparam logic [6:0] O_CHECK = 7'b1_00_1_00_1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1, bat_below_low = 1'b1, bat_below_rch = 1'b1;
    logic bat_at_reg = 1'b0, cur_below_taper = 1'b0, cur_below_term = 1'b0;
    logic temp_ok = 1'b1, die_hot = 1'b0, chg_en_n = 1'b0, tte_n = 1'b0;
    logic tick_1s = 1'b0, absent_done = 1'b0, absent_found = 1'b0;
    logic sel_precharge, fast_en, charger_off, stat1_on, stat2_on, pgood_on, absent_req;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cellchg_seq #(.PRE_LIMIT(PRE_L), .FAST_LIMIT(FAST_L), .TAPER_LIMIT(TAPER_L)) u_cellchg_seq (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .bat_below_low(bat_below_low),
        .bat_below_rch(bat_below_rch), .bat_at_reg(bat_at_reg),
        .cur_below_taper(cur_below_taper), .cur_below_term(cur_below_term),
        .temp_ok(temp_ok), .die_hot(die_hot), .chg_en_n(chg_en_n), .tte_n(tte_n),
        .tick_1s(tick_1s), .absent_done(absent_done), .absent_found(absent_found),
        .sel_precharge(sel_precharge), .fast_en(fast_en), .charger_off(charger_off),
        .stat1_on(stat1_on), .stat2_on(stat2_on), .pgood_on(pgood_on), .absent_req(absent_req)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [6:0] outs();
        return {pgood_on, stat1_on, stat2_on, charger_off, sel_precharge, fast_en, absent_req};
    endfunction

    task automatic chk(input string req, input logic [6:0] exp);
        tests = tests + 1;
        if (outs() !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual=%b expected=%b", req, outs(), exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_1s = 1'b1;
            step();
            tick_1s = 1'b0;
            step();
        end
    endtask

    // Reset with default inputs; leaves the block one cycle after release.
    task automatic do_reset(input logic low);
        @(negedge clk);
        rst_n = 1'b0;
        supply_ok = 1'b1; bat_below_low = low; bat_below_rch = 1'b1;
        bat_at_reg = 1'b0; cur_below_taper = 1'b0; cur_below_term = 1'b0;
        temp_ok = 1'b1; die_hot = 1'b0; chg_en_n = 1'b0; tte_n = 1'b0;
        tick_1s = 1'b0; absent_done = 1'b0; absent_found = 1'b0;
        step(3);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset_and_precharge();
        @(negedge clk);
        rst_n = 1'b0;
        step(2);
        chk("R1 reset state", O_SLEEP);
        rst_n = 1'b1;
        step();
        chk("R2 precharge entry", O_PRE);
    endtask

    task automatic t_precharge_timeout();
        do_reset(1'b1);
        ticks(PRE_L - 1);
        step();
        chk("R3 one tick short of limit", O_PRE);
        ticks(1);
        step();
        chk("R3 precharge timer fault", O_IDLE);
        chg_en_n = 1'b1;
        step();
        chk("R8 charge disabled", O_IDLE);
        chg_en_n = 1'b0;
        step();
        chk("R8 falling edge restarts cycle", O_PRE);
    endtask

    task automatic t_fast_and_back();
        do_reset(1'b1);
        ticks(5);
        bat_below_low = 1'b0; bat_below_rch = 1'b0;
        step();
        chk("R4 enter full charge", O_FAST);
        bat_below_low = 1'b1; bat_below_rch = 1'b1;
        step();
        chk("R13 back to conditioning", O_PRE);
        ticks(PRE_L - 1);
        step();
        chk("R13 conditioning timer was cleared", O_PRE);
        bat_below_low = 1'b0; bat_below_rch = 1'b0;
        step();
        ticks(FAST_L - 1);
        step();
        chk("R4 full-charge timer one short", O_FAST);
        ticks(1);
        step();
        chk("R4 full-charge timer fault", O_IDLE);
    endtask

    task automatic t_taper();
        do_reset(1'b0);
        bat_below_rch = 1'b0;
        step();
        chk("R4 full charge from reset", O_FAST);
        bat_at_reg = 1'b1; cur_below_taper = 1'b1;
        ticks(3);
        cur_below_taper = 1'b0;
        step();
        ticks(1);
        cur_below_taper = 1'b1;
        step();
        ticks(TAPER_L - 1);
        step();
        chk("R5 taper count restarted, one short", O_FAST);
        ticks(1);
        step();
        chk("R5 taper expiry ends charge", O_DONE);
    endtask

    task automatic t_term_and_absent();
        do_reset(1'b0);
        bat_below_rch = 1'b0;
        step();
        bat_at_reg = 1'b1; cur_below_taper = 1'b1; cur_below_term = 1'b1;
        step();
        chk("R6 immediate termination", O_DONE);
        bat_at_reg = 1'b0; cur_below_taper = 1'b0; cur_below_term = 1'b0;
        bat_below_rch = 1'b1;
        step();
        chk("R11 absent request after done", O_CHECK);
        absent_done = 1'b1; absent_found = 1'b1;
        step();
        absent_done = 1'b0; absent_found = 1'b0;
        chk("R11 absent state status off", O_IDLE);
        bat_below_rch = 1'b0;
        step();
        chk("R11 absent exit restarts cycle", O_FAST);
    endtask

    task automatic t_suspend();
        do_reset(1'b1);
        ticks(5);
        temp_ok = 1'b0;
        step();
        chk("R7 temperature suspend", O_IDLE);
        ticks(10);
        temp_ok = 1'b1;
        step();
        chk("R7 resume conditioning", O_PRE);
        die_hot = 1'b1;
        step();
        chk("R7 die hot suspend", O_IDLE);
        die_hot = 1'b0;
        step();
        ticks(PRE_L - 5 - 1);
        step();
        chk("R7 timer held during suspend", O_PRE);
        ticks(1);
        step();
        chk("R7 held timer expires at limit", O_IDLE);
    endtask

    task automatic t_tte();
        do_reset(1'b0);
        bat_below_rch = 1'b0;
        tte_n = 1'b1;
        step();
        ticks(FAST_L + 5);
        step();
        chk("R9 full-charge timer disabled", O_FAST);
        bat_at_reg = 1'b1; cur_below_term = 1'b1;
        step(2);
        chk("R9 termination disabled", O_FAST);
        bat_at_reg = 1'b0; cur_below_term = 1'b0;
        tte_n = 1'b0;
        step();
        ticks(15);
        tte_n = 1'b1;
        step();
        tte_n = 1'b0;
        step();
        ticks(FAST_L - 1);
        step();
        chk("R9 falling edge cleared timers", O_FAST);
        ticks(1);
        step();
        chk("R9 timer runs again after enable", O_IDLE);
    endtask

    task automatic t_fault_recovery();
        do_reset(1'b1);
        ticks(PRE_L);
        step();
        chk("R12 fault with battery below recharge", O_IDLE);
        step(3);
        chk("R12 no absent request while still low", O_IDLE);
        bat_below_rch = 1'b0;
        step(2);
        chk("R12 waits above recharge threshold", O_IDLE);
        bat_below_rch = 1'b1;
        step();
        chk("R12 absent request after fall", O_CHECK);
        absent_done = 1'b1; absent_found = 1'b0;
        step();
        absent_done = 1'b0;
        chk("R11 battery present restarts cycle", O_PRE);
    endtask

    task automatic t_supply_loss();
        do_reset(1'b0);
        bat_below_rch = 1'b0;
        step();
        supply_ok = 1'b0;
        step();
        chk("R1 supply loss sleep", O_SLEEP);
        step(2);
        chk("R10 sleep status off", O_SLEEP);
        supply_ok = 1'b1;
        step();
        chk("R1 supply return restarts", O_FAST);
    endtask

    initial begin
        t_reset_and_precharge();
        t_precharge_timeout();
        t_fast_and_back();
        t_taper();
        t_term_and_absent();
        t_suspend();
        t_tte();
        t_fault_recovery();
        t_supply_loss();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule